// File: doc/BRIEF.md
# Multi-Queue Circular Buffer Status Engine

This block manages a set of hardware queues that all live in one shared, word-addressed SRAM. Each queue is a circular buffer. Its state is held in a single 32-bit configuration word: read and write pointers, a base block number, an entry width, a buffer size and two log-encoded watermarks.

A client issues push or pop requests for a given queue. An entry is one, two or four 32-bit words, and the whole entry moves in a single cycle. The engine forms the SRAM word addresses from the queue base and the active pointer, wrapping inside the buffer. It moves the pointer and updates the fill level. It also derives four status flags per queue: empty, nearly-empty, nearly-full and full.

A request that would overflow or underflow a queue is refused, leaves the queue untouched and sets a sticky error bit. Software reaches the configuration words, the packed status words and the sticky bits through a simple register port whose read data is registered.

Top module: `qbuf_status_engine`

## Requirements
- R1: After reset the register port reads the following:
  - every configuration word reads 0;
  - each lower status word (0x40..0x43) reads 0x33333333;
  - the upper nearly-empty word (0x44) reads 0xFFFFFFFF;
  - the upper full word (0x45) and all sticky words (0x48, 0x49, 0x4C, 0x4D) read 0.
- R2: The configuration word of queue q is at register address q.
  - Its fields are: write pointer [6:0], read pointer [13:7], base block [21:14], entry-size code [23:22], buffer-size code [25:24], nearly-empty code [28:26] and nearly-full code [31:29].
  - A write is readable unchanged. `reg_rdata` shows the word selected by `reg_addr` one clock later.
- R3: An accepted push writes entry word i (from `req_wdata` bits 32i+31:32i) to SRAM word base×16 + ((wrptr + i) mod size_words). It then advances the write pointer by the entry width modulo size_words.
  - `rsp_valid` is high in the cycle after every request.
  - `rsp_ok` is high in that cycle when the request was accepted.
- R4: An accepted pop returns the word at base×16 + ((rdptr + i) mod size_words) on `rsp_rdata` lane i (bits 32i+31:32i) one cycle after the request.
  - Lanes beyond the entry width read 0.
  - The read pointer advances by the entry width modulo size_words.
- R5: Entry-size code 0 selects 1 word, code 1 selects 2 words, and codes 2 and 3 select 4 words. An entry may straddle the end of the buffer.
- R6: Buffer-size codes 0..3 select 16, 32, 64 and 128 words. Pointers wrap at that size, and the fill level never exceeds it.
- R7: Queue q < 32 reports a status nibble in word 0x40 + q/8, bits 4×(q mod 8) upward:
  - bit 0 is empty (no complete entry stored);
  - bit 1 is nearly-empty;
  - bit 2 is nearly-full;
  - bit 3 is full (no room for one more entry).
- R8: A push to a full queue is refused.
  - `rsp_ok` reads 0, and the pointers and data stay unchanged.
  - Overflow bit q is set in word 0x4C + q/32, bit q mod 32.
- R9: A pop from an empty queue is refused.
  - `rsp_ok` and `rsp_rdata` read 0.
  - Underflow bit q is set in word 0x48 + q/32, bit q mod 32.
- R10: Watermark code c gives a threshold T = 0 for c = 0 and 2^(c−1) otherwise.
  - Nearly-empty is set when the stored entries are ≤ T(NE code).
  - Nearly-full is set when the free entries are ≤ T(NF code).
- R11: For queue q ≥ 32, word 0x44 bit (q − 32) is its nearly-empty flag and word 0x45 bit (q − 32) is its full flag.
- R12: Writing a sticky word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R13: Writing a configuration word sets that queue's fill to (wrptr − rdptr) mod size_words. A request to the same queue in the same cycle is refused with no SRAM, pointer or sticky effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Queue request strobe |
| req_push | input | 1 | 1 = push, 0 = pop |
| req_qid | input | QID_W (6) | Target queue |
| req_wdata | input | 128 | Push entry words, word i in bits 32i+31:32i |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rsp_ok | output | 1 | Previous request was accepted |
| rsp_rdata | output | 128 | Popped entry words, unused lanes zero |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of `reg_addr` |

## Verification
A one-word queue is filled to capacity and then drained. This exposes the empty/full edges and the watermark thresholds one entry at a time, and a further push and pop at each edge separate the refusal path from the normal path.

A two-word queue is run past its end, which shows that pointers wrap modulo the buffer size and not modulo the pointer width. A four-word queue with its pointers preset two words before the end shows whether an entry is split across the wrap in the correct word order.

An upper queue shows the single-bit status packing. A configuration write aimed at the queue being pushed in the same cycle tells the refusal rule apart from silently merged updates.

// File: rtl/qse_pkg.sv
package qse_pkg;

    localparam int WORD_W    = 32;
    localparam int PTR_W     = 7;
    localparam int BASE_W    = 8;
    localparam int LANES     = 4;
    localparam int BLK_SHIFT = 4;
    localparam int FILL_W    = 8;
    localparam int REG_AW    = 8;
    localparam int ADDR_FW   = BASE_W + BLK_SHIFT + 1;

    // register map
    localparam int ADR_LSTAT = 'h40;
    localparam int ADR_UNE   = 'h44;
    localparam int ADR_UFULL = 'h45;
    localparam int ADR_UNF   = 'h48;
    localparam int ADR_OVF   = 'h4C;

    typedef struct packed {
        logic [2:0]        nf_code;
        logic [2:0]        ne_code;
        logic [1:0]        buf_code;
        logic [1:0]        ent_code;
        logic [BASE_W-1:0] base;
        logic [PTR_W-1:0]  rd;
        logic [PTR_W-1:0]  wr;
    } qcfg_t;

    typedef struct packed {
        logic full;
        logic near_full;
        logic near_empty;
        logic empty;
    } qflag_t;

    function automatic logic [FILL_W-1:0] size_words(logic [1:0] code);
        return 8'd16 << code;
    endfunction

    function automatic logic [2:0] entry_words(logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] entry_shift(logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [FILL_W-1:0] wm_thresh(logic [2:0] code);
        return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
    endfunction

    function automatic logic [FILL_W-1:0] fill_from_ptrs(qcfg_t c);
        logic [FILL_W-1:0] d;
        d = {1'b0, c.wr} - {1'b0, c.rd};
        return d & (size_words(c.buf_code) - 8'd1);
    endfunction

endpackage

// File: rtl/qse_flags.sv
module qse_flags
    import qse_pkg::*;
#(
    parameter int NUM_Q = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  qcfg_t             cfg  [NUM_Q],
    input  logic [FILL_W-1:0] fill [NUM_Q],
    output qflag_t            flg  [NUM_Q]
);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [FILL_W-1:0] sz;
        logic [FILL_W-1:0] used_e;
        logic [FILL_W-1:0] free_e;
        logic [1:0]        sh;

        assign sh     = entry_shift(cfg[q].ent_code);
        assign sz     = size_words(cfg[q].buf_code);
        assign used_e = fill[q] >> sh;
        assign free_e = (sz - fill[q]) >> sh;

        assign flg[q].empty      = (used_e == '0);
        assign flg[q].full       = (free_e == '0);
        assign flg[q].near_empty = (used_e <= wm_thresh(cfg[q].ne_code));
        assign flg[q].near_full  = (free_e <= wm_thresh(cfg[q].nf_code));

        // a queue of nonzero size can never be empty and full together
        p_not_empty_and_full_r7: assert property (@(posedge clk) disable iff (rst)
            !(flg[q].empty && flg[q].full));
    end

endmodule

// File: rtl/qse_access.sv
module qse_access
    import qse_pkg::*;
#(
    parameter int SRAM_AW = 11
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_valid,
    input  logic                            req_push,
    input  logic                            blocked,
    input  qcfg_t                           cfg_sel,
    input  logic [FILL_W-1:0]               fill_sel,
    input  qflag_t                          flag_sel,
    output logic                            acc,
    output logic                            ovf_evt,
    output logic                            unf_evt,
    output logic                            sram_we,
    output logic                            sram_re,
    output logic [LANES-1:0]                lane_en,
    output logic [LANES-1:0][SRAM_AW-1:0]   lane_addr,
    output qcfg_t                           upd_cfg,
    output logic [FILL_W-1:0]               upd_fill
);

    logic [2:0]         ew;
    logic [PTR_W-1:0]   smask;
    logic [PTR_W-1:0]   ptr;
    logic [PTR_W-1:0]   nxt;
    logic [ADDR_FW-1:0] blk_addr;
    logic               room;
    logic               live;

    assign ew       = entry_words(cfg_sel.ent_code);
    assign smask    = PTR_W'(size_words(cfg_sel.buf_code) - 8'd1);
    assign ptr      = req_push ? cfg_sel.wr : cfg_sel.rd;
    assign nxt      = (ptr + PTR_W'(ew)) & smask;
    assign blk_addr = {1'b0, cfg_sel.base, {BLK_SHIFT{1'b0}}};

    assign live    = req_valid && !blocked;
    assign room    = req_push ? !flag_sel.full : !flag_sel.empty;
    assign acc     = live && room;
    assign ovf_evt = live && req_push && flag_sel.full;
    assign unf_evt = live && !req_push && flag_sel.empty;
    assign sram_we = acc && req_push;
    assign sram_re = acc && !req_push;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PTR_W-1:0]   off;
        logic [ADDR_FW-1:0] full_addr;
        assign off          = (ptr + PTR_W'(i)) & smask;
        assign full_addr    = blk_addr + ADDR_FW'(off);
        assign lane_addr[i] = full_addr[SRAM_AW-1:0];
        assign lane_en[i]   = (3'(i) < ew);
    end

    always_comb begin
        upd_cfg = cfg_sel;
        if (req_push) begin
            upd_cfg.wr = nxt;
            upd_fill   = fill_sel + FILL_W'(ew);
        end else begin
            upd_cfg.rd = nxt;
            upd_fill   = fill_sel - FILL_W'(ew);
        end
    end

    // a pop is only let through when the stored fill holds a whole entry
    p_pop_has_entry_r9: assert property (@(posedge clk) disable iff (rst)
        sram_re |-> (fill_sel >= FILL_W'(ew)));

    // a push is only let through when the fill leaves room for a whole entry
    p_push_has_room_r8: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> ((FILL_W'(fill_sel) + FILL_W'(ew)) <= size_words(cfg_sel.buf_code)));

endmodule

// File: rtl/qse_sram.sv
module qse_sram
    import qse_pkg::*;
#(
    parameter int SRAM_AW = 11
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic                          re,
    input  logic [LANES-1:0]              lane_en,
    input  logic [LANES-1:0][SRAM_AW-1:0] lane_addr,
    input  logic [LANES*WORD_W-1:0]       wdata,
    output logic [LANES*WORD_W-1:0]       rdata
);

    localparam int DEPTH = 1 << SRAM_AW;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (we && lane_en[i]) begin
                mem[lane_addr[i]] <= wdata[i*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                rdata[i*WORD_W +: WORD_W] <= (re && lane_en[i]) ? mem[lane_addr[i]] : '0;
            end
        end
    end

endmodule

// File: rtl/qse_cfg_bank.sv
module qse_cfg_bank
    import qse_pkg::*;
#(
    parameter int QID_W = 6,
    parameter int NUM_Q = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [QID_W-1:0]  cfg_idx,
    input  qcfg_t             cfg_wdata,
    input  logic              upd_en,
    input  logic [QID_W-1:0]  upd_qid,
    input  qcfg_t             upd_cfg,
    input  logic [FILL_W-1:0] upd_fill,
    input  logic              unf_evt,
    input  logic              ovf_evt,
    input  logic [NUM_Q-1:0]  clr_unf,
    input  logic [NUM_Q-1:0]  clr_ovf,
    output qcfg_t             cfg_q  [NUM_Q],
    output logic [FILL_W-1:0] fill_q [NUM_Q],
    output logic [NUM_Q-1:0]  unf_q,
    output logic [NUM_Q-1:0]  ovf_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NUM_Q; q++) begin
                cfg_q[q]  <= '0;
                fill_q[q] <= '0;
            end
            unf_q <= '0;
            ovf_q <= '0;
        end else begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (cfg_we && cfg_idx == QID_W'(q)) begin
                    cfg_q[q]  <= cfg_wdata;
                    fill_q[q] <= fill_from_ptrs(cfg_wdata);
                end else if (upd_en && upd_qid == QID_W'(q)) begin
                    cfg_q[q]  <= upd_cfg;
                    fill_q[q] <= upd_fill;
                end
                unf_q[q] <= (unf_q[q] & ~clr_unf[q]) | (unf_evt && upd_qid == QID_W'(q));
                ovf_q[q] <= (ovf_q[q] & ~clr_ovf[q]) | (ovf_evt && upd_qid == QID_W'(q));
            end
        end
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
            fill_q[q] <= size_words(cfg_q[q].buf_code));
    end

    p_sticky_unf_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(|clr_unf) |=> ((unf_q & $past(unf_q)) == $past(unf_q)));

    p_sticky_ovf_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(|clr_ovf) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

endmodule

// File: rtl/qbuf_status_engine.sv
module qbuf_status_engine
    import qse_pkg::*;
#(
    parameter int QID_W   = 6,
    parameter int SRAM_AW = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_push,
    input  logic [QID_W-1:0]        req_qid,
    input  logic [LANES*WORD_W-1:0] req_wdata,
    output logic                    rsp_valid,
    output logic                    rsp_ok,
    output logic [LANES*WORD_W-1:0] rsp_rdata,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic                    reg_we,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata
);

    localparam int NUM_Q = 1 << QID_W;
    localparam int LOW_Q = NUM_Q / 2;

    qcfg_t                         cfg_arr  [NUM_Q];
    logic [FILL_W-1:0]             fill_arr [NUM_Q];
    qflag_t                        flg      [NUM_Q];
    logic [NUM_Q-1:0]              unf_bits;
    logic [NUM_Q-1:0]              ovf_bits;
    logic [NUM_Q-1:0]              clr_unf;
    logic [NUM_Q-1:0]              clr_ovf;
    logic                          cfg_we;
    logic                          blocked;
    logic                          acc;
    logic                          ovf_evt;
    logic                          unf_evt;
    logic                          sram_we;
    logic                          sram_re;
    logic [LANES-1:0]              lane_en;
    logic [LANES-1:0][SRAM_AW-1:0] lane_addr;
    qcfg_t                         upd_cfg;
    logic [FILL_W-1:0]             upd_fill;
    logic [WORD_W-1:0]             rd_word;

    assign cfg_we  = reg_we && (int'(reg_addr) < NUM_Q);
    assign blocked = cfg_we && (reg_addr[QID_W-1:0] == req_qid);

    always_comb begin
        for (int q = 0; q < NUM_Q; q++) begin
            clr_unf[q] = reg_we && (int'(reg_addr) == ADR_UNF + q / 32) && reg_wdata[q % 32];
            clr_ovf[q] = reg_we && (int'(reg_addr) == ADR_OVF + q / 32) && reg_wdata[q % 32];
        end
    end

    qse_cfg_bank #(.QID_W(QID_W), .NUM_Q(NUM_Q)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (reg_addr[QID_W-1:0]),
        .cfg_wdata(qcfg_t'(reg_wdata)),
        .upd_en   (acc),
        .upd_qid  (req_qid),
        .upd_cfg  (upd_cfg),
        .upd_fill (upd_fill),
        .unf_evt  (unf_evt),
        .ovf_evt  (ovf_evt),
        .clr_unf  (clr_unf),
        .clr_ovf  (clr_ovf),
        .cfg_q    (cfg_arr),
        .fill_q   (fill_arr),
        .unf_q    (unf_bits),
        .ovf_q    (ovf_bits)
    );

    qse_flags #(.NUM_Q(NUM_Q)) u_flags (
        .clk (clk),
        .rst (rst),
        .cfg (cfg_arr),
        .fill(fill_arr),
        .flg (flg)
    );

    qse_access #(.SRAM_AW(SRAM_AW)) u_access (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_push (req_push),
        .blocked  (blocked),
        .cfg_sel  (cfg_arr[req_qid]),
        .fill_sel (fill_arr[req_qid]),
        .flag_sel (flg[req_qid]),
        .acc      (acc),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt),
        .sram_we  (sram_we),
        .sram_re  (sram_re),
        .lane_en  (lane_en),
        .lane_addr(lane_addr),
        .upd_cfg  (upd_cfg),
        .upd_fill (upd_fill)
    );

    qse_sram #(.SRAM_AW(SRAM_AW)) u_sram (
        .clk      (clk),
        .rst      (rst),
        .we       (sram_we),
        .re       (sram_re),
        .lane_en  (lane_en),
        .lane_addr(lane_addr),
        .wdata    (req_wdata),
        .rdata    (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= acc;
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(reg_addr) < NUM_Q) begin
            rd_word = cfg_arr[reg_addr[QID_W-1:0]];
        end else begin
            for (int q = 0; q < LOW_Q; q++) begin
                if (int'(reg_addr) == ADR_LSTAT + q / 8) rd_word[4*(q%8) +: 4] = flg[q];
            end
            for (int q = LOW_Q; q < NUM_Q; q++) begin
                if (int'(reg_addr) == ADR_UNE)   rd_word[q-LOW_Q] = flg[q].near_empty;
                if (int'(reg_addr) == ADR_UFULL) rd_word[q-LOW_Q] = flg[q].full;
            end
            for (int q = 0; q < NUM_Q; q++) begin
                if (int'(reg_addr) == ADR_UNF + q / 32) rd_word[q%32] = unf_bits[q];
                if (int'(reg_addr) == ADR_OVF + q / 32) rd_word[q%32] = ovf_bits[q];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else     reg_rdata <= rd_word;
    end

    // checker state: the selected queue's word as seen at request time
    logic [QID_W-1:0] chk_qid;
    qcfg_t            chk_cfg;
    logic             chk_cw;

    always_ff @(posedge clk) begin
        chk_qid <= req_qid;
        chk_cfg <= cfg_arr[req_qid];
        chk_cw  <= cfg_we;
    end

    p_rsp_follows_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_reject_no_data_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok) |-> (rsp_rdata == '0));

    p_reject_keeps_cfg_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ok && !chk_cw) |-> (cfg_arr[chk_qid] == chk_cfg));

endmodule

// File: tb/sim_qbuf_status_engine.sv
`timescale 1ns/1ps
module sim_qbuf_status_engine;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_push = 1'b0;
    logic [5:0]   req_qid = '0;
    logic [127:0] req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_ok;
    logic [127:0] rsp_rdata;
    logic [7:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;

    always #2.5 clk = ~clk;

    qbuf_status_engine u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_push(req_push), .req_qid(req_qid), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_wr[64], m_rd[64], m_base[64], m_es[64], m_bs[64], m_ne[64], m_nf[64], m_cnt[64];
    bit m_unf[64], m_ovf[64];
    logic [31:0] m_mem [int];

    function automatic int m_ew(int q);
        return (m_es[q] == 0) ? 1 : (m_es[q] == 1) ? 2 : 4;
    endfunction

    function automatic int m_sz(int q);
        return 16 << m_bs[q];
    endfunction

    function automatic int m_thr(int c);
        return (c == 0) ? 0 : (1 << (c - 1));
    endfunction

    function automatic logic [3:0] m_flags(int q);
        int used = m_cnt[q] / m_ew(q);
        int free = (m_sz(q) - m_cnt[q]) / m_ew(q);
        return {free == 0, free <= m_thr(m_nf[q]), used <= m_thr(m_ne[q]), used == 0};
    endfunction

    function automatic logic [31:0] model_reg(int a);
        logic [31:0] v = '0;
        if (a < 64) begin
            v = (m_nf[a] << 29) | (m_ne[a] << 26) | (m_bs[a] << 24) | (m_es[a] << 22)
              | (m_base[a] << 14) | (m_rd[a] << 7) | m_wr[a];
        end else if (a >= 'h40 && a <= 'h43) begin
            for (int k = 0; k < 8; k++) v[4*k +: 4] = m_flags((a - 'h40) * 8 + k);
        end else if (a == 'h44 || a == 'h45) begin
            for (int q = 32; q < 64; q++) begin
                logic [3:0] f = m_flags(q);
                v[q-32] = (a == 'h44) ? f[1] : f[3];
            end
        end else if (a == 'h48 || a == 'h49) begin
            for (int k = 0; k < 32; k++) v[k] = m_unf[(a - 'h48) * 32 + k];
        end else if (a == 'h4C || a == 'h4D) begin
            for (int k = 0; k < 32; k++) v[k] = m_ovf[(a - 'h4C) * 32 + k];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_cfg(input int q, input logic [31:0] d);
        m_wr[q] = d[6:0];   m_rd[q] = d[13:7]; m_base[q] = d[21:14]; m_es[q] = d[23:22];
        m_bs[q] = d[25:24]; m_ne[q] = d[28:26]; m_nf[q] = d[31:29];
        m_cnt[q] = (m_wr[q] - m_rd[q] + 256) % m_sz(q);
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a < 64) model_cfg(a, d);
        for (int k = 0; k < 32; k++) begin
            if (d[k] && (a == 'h48 || a == 'h49)) m_unf[(a - 'h48) * 32 + k] = 1'b0;
            if (d[k] && (a == 'h4C || a == 'h4D)) m_ovf[(a - 'h4C) * 32 + k] = 1'b0;
        end
    endtask

    task automatic reg_check(input int a, input string tag);
        @(negedge clk);
        reg_addr = 8'(a);
        @(negedge clk);
        chk(tag, 128'(reg_rdata), 128'(model_reg(a)));
    endtask

    function automatic logic [31:0] cfg_word(int wr, int rd, int base, int es, int bs, int ne, int nf);
        return 32'((nf << 29) | (ne << 26) | (bs << 24) | (es << 22) | (base << 14) | (rd << 7) | wr);
    endfunction

    function automatic logic [127:0] mk_data(int q, int seq);
        logic [127:0] d;
        for (int i = 0; i < 4; i++) d[32*i +: 32] = {8'(q), 8'(i), 16'(seq)};
        return d;
    endfunction

    task automatic do_op(input bit push, input int q, input logic [127:0] d, input string tag);
        bit exp_ok;
        logic [127:0] exp_rd = '0;
        int ew = m_ew(q);
        int sz = m_sz(q);
        @(negedge clk);
        req_valid = 1'b1; req_push = push; req_qid = 6'(q); req_wdata = d;
        if (push) begin
            exp_ok = ((sz - m_cnt[q]) / ew) != 0;
            if (exp_ok) begin
                for (int i = 0; i < ew; i++)
                    m_mem[(m_base[q] * 16 + (m_wr[q] + i) % sz) % 2048] = d[32*i +: 32];
                m_wr[q] = (m_wr[q] + ew) % sz;
                m_cnt[q] += ew;
            end else m_ovf[q] = 1'b1;
        end else begin
            exp_ok = (m_cnt[q] / ew) != 0;
            if (exp_ok) begin
                for (int i = 0; i < ew; i++)
                    exp_rd[32*i +: 32] = m_mem[(m_base[q] * 16 + (m_rd[q] + i) % sz) % 2048];
                m_rd[q] = (m_rd[q] + ew) % sz;
                m_cnt[q] -= ew;
            end else m_unf[q] = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " valid"}, 128'(rsp_valid), 128'(1));
        chk({tag, " ok"}, 128'(rsp_ok), 128'(exp_ok));
        if (!push) chk({tag, " rdata"}, rsp_rdata, exp_rd);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int q = 0; q < 64; q++) model_cfg(q, '0);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_check(0, "R1 cfg0");
        reg_check(63, "R1 cfg63");
        for (int a = 'h40; a <= 'h45; a++) reg_check(a, "R1 status");
        reg_check('h48, "R1 unf");
        reg_check('h4D, "R1 ovf");
        @(negedge clk);
        chk("R3 idle rsp", 128'(rsp_valid), 128'(0));

        // R2 layout readback, one-word queue 0
        reg_write(0, cfg_word(0, 0, 2, 0, 0, 2, 2));
        reg_check(0, "R2 cfg0 readback");

        // R3 R7 R10 fill queue 0 entry by entry
        for (int n = 0; n < 16; n++) begin
            do_op(1, 0, mk_data(0, n), "R3 push q0");
            reg_check('h40, "R7 R10 status q0 filling");
        end
        // R8 overflow
        do_op(1, 0, mk_data(0, 99), "R8 push full q0");
        reg_check(0, "R8 ptr unchanged q0");
        reg_check('h4C, "R8 sticky ovf");
        // R4 drain
        for (int n = 0; n < 16; n++) begin
            do_op(0, 0, '0, "R4 pop q0");
            reg_check('h40, "R10 status q0 draining");
        end
        // R9 underflow
        do_op(0, 0, '0, "R9 pop empty q0");
        reg_check('h48, "R9 sticky unf");
        reg_check(0, "R9 ptr unchanged q0");

        // R12 W1C
        reg_write('h4C, 32'h0);
        reg_check('h4C, "R12 zero write keeps ovf");
        reg_write('h4C, 32'h1);
        reg_check('h4C, "R12 w1c ovf");
        reg_write('h48, 32'h1);
        reg_check('h48, "R12 w1c unf");

        // R5 R6 two-word queue 1, 32 words, wraps
        reg_write(1, cfg_word(0, 0, 4, 1, 1, 3, 1));
        for (int n = 0; n < 12; n++) do_op(1, 1, mk_data(1, n), "R5 push q1");
        reg_check('h40, "R10 status q1");
        for (int n = 0; n < 10; n++) do_op(0, 1, '0, "R5 pop q1");
        for (int n = 12; n < 22; n++) do_op(1, 1, mk_data(1, n), "R6 push q1 wrap");
        reg_check(1, "R6 ptr wrap q1");
        reg_check('h40, "R7 status q1 wrapped");
        for (int n = 0; n < 12; n++) do_op(0, 1, '0, "R6 pop q1 wrap");

        // R5 R6 four-word queue 2 straddling the end of a 16-word buffer
        reg_write(2, cfg_word(14, 14, 6, 2, 0, 1, 1));
        for (int n = 0; n < 4; n++) do_op(1, 2, mk_data(2, n), "R5 push q2");
        reg_check('h40, "R7 full q2");
        do_op(1, 2, mk_data(2, 9), "R8 push full q2");
        for (int n = 0; n < 4; n++) do_op(0, 2, '0, "R5 pop q2 straddle");

        // R11 upper queue 40
        reg_write(40, cfg_word(0, 0, 8, 0, 0, 1, 0));
        do_op(1, 40, mk_data(40, 0), "R11 push q40");
        reg_check('h44, "R11 upper ne one");
        do_op(1, 40, mk_data(40, 1), "R11 push q40");
        reg_check('h44, "R11 upper ne two");
        for (int n = 2; n < 16; n++) do_op(1, 40, mk_data(40, n), "R11 push q40");
        reg_check('h45, "R11 upper full");
        do_op(1, 40, mk_data(40, 16), "R8 push full q40");
        reg_check('h4D, "R8 sticky ovf upper");
        do_op(0, 40, '0, "R4 pop q40");
        reg_check('h45, "R11 upper not full");

        // R13 config write sets fill; same-cycle request is refused
        reg_write(3, cfg_word(5, 1, 10, 0, 0, 3, 0));
        reg_check('h40, "R13 fill from ptrs");
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'd3; reg_wdata = cfg_word(2, 0, 10, 0, 0, 1, 0);
        req_valid = 1'b1; req_push = 1'b1; req_qid = 6'd3; req_wdata = mk_data(3, 0);
        @(negedge clk);
        reg_we = 1'b0; req_valid = 1'b0;
        model_cfg(3, cfg_word(2, 0, 10, 0, 0, 1, 0));
        chk("R13 collide valid", 128'(rsp_valid), 128'(1));
        chk("R13 collide refused", 128'(rsp_ok), 128'(0));
        reg_check(3, "R13 cfg after collide");
        reg_check('h40, "R13 status after collide");
        reg_check('h4C, "R13 no sticky");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule